// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

The block derives a slower clock from its input clock at an exact rational ratio `NUM_OUT / NUM_IN` with no long-term drift. Each output cycle lasts either two or three input clocks. A small controller picks the length of every output cycle so that exactly `NUM_OUT` output cycles fill every frame of `NUM_IN` input clocks. With the default parameters, a 32 MHz source yields 12.288 MHz exactly. Each 125-clock frame holds 29 three-clock cycles and 19 two-clock cycles, so the pattern repeats at 256 kHz.

Two elaboration-time options set the output quality. With `MIN_JITTER` set, an error accumulator spreads the long and short cycles evenly, which keeps the phase error near one input period. With it clear, a frame runs all long cycles first and then all short cycles. This is simpler but gives a much larger phase wander. With `DUTY_FIX` set, the divided clock stays high for about half of each cycle instead of for a single input clock. Both outputs are registers clocked by the input clock, so they are glitch-free and aligned to it.

Top module: `fdiv_top`

## Requirements
- R1: Every output cycle lasts 2 or 3 input clocks. `pulse_o` is high for exactly one input clock, in the last input clock of each output cycle.
- R2: Starting from reset release, every consecutive window of `NUM_IN` input clocks holds exactly `NUM_OUT` pulses on `pulse_o`.
- R3: With `MIN_JITTER` = 1, the cycle lengths follow an accumulator that starts at 0. For each output cycle, `NUM_IN - 2*NUM_OUT` is added to it. If the sum is at least `NUM_OUT`, the cycle lasts 3 clocks and `NUM_OUT` is subtracted; otherwise the cycle lasts 2 clocks. For the default ratio, no two 2-clock cycles are adjacent.
- R4: With `MIN_JITTER` = 0, each frame opens with `NUM_IN - 2*NUM_OUT` cycles of 3 clocks, followed by `3*NUM_OUT - NUM_IN` cycles of 2 clocks.
- R5: With `DUTY_FIX` = 0, `clk_div_o` is high only in the first input clock of each output cycle.
- R6: With `DUTY_FIX` = 1, `clk_div_o` is high for the first 1 input clock of a 2-clock cycle and for the first 2 input clocks of a 3-clock cycle.
- R7: While `rst` is high, both outputs are low from the next clock onward. The first clock edge after release starts output cycle 0, so `clk_div_o` goes high in the clock that follows that edge. Each reset restarts the frame at that same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pulse_o | output | 1 | One-clock enable at the end of each output cycle |
| clk_div_o | output | 1 | Divided clock, registered |

## Verification
The end of one output cycle and the start of the next fall on the same clock edge. At that edge the prescaler wraps, the controller advances to choose the next length, and both output registers change. The bench checks every output against an arithmetic model on every clock for four parameter sets: 48/125, 3/7, 5/13 and a grouped 48/125. That covers the boundaries between 3-clock and 2-clock cycles and the points where the accumulator crosses its threshold. A reset asserted mid-frame collides with a running frame, and the bench expects the next frame to start again from cycle 0.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic {
        DIV_BY_2 = 1'b0,
        DIV_BY_3 = 1'b1
    } ratio_e;

    typedef struct packed {
        logic [1:0] phase;   // input clocks elapsed in current output cycle
        logic       last;    // final input clock of current output cycle
    } presc_s;

    function automatic int unsigned long_count(int unsigned n_out, int unsigned n_in);
        return n_in - 2 * n_out;
    endfunction

    function automatic int unsigned short_count(int unsigned n_out, int unsigned n_in);
        return 3 * n_out - n_in;
    endfunction

    function automatic logic [1:0] final_phase(ratio_e r);
        return (r == DIV_BY_3) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] high_len(ratio_e r, bit duty);
        if (duty && r == DIV_BY_3) return 2'd2;
        return 2'd1;
    endfunction

endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 48,
    parameter int unsigned NUM_IN     = 125,
    parameter bit          MIN_JITTER = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output ratio_e ratio
);
    localparam int unsigned N_LONG  = long_count(NUM_OUT, NUM_IN);
    localparam int unsigned N_SHORT = short_count(NUM_OUT, NUM_IN);
    localparam int unsigned ACC_W   = $clog2(NUM_OUT) + 1;
    localparam int unsigned SUM_W   = ACC_W + 1;

    generate
        if (MIN_JITTER) begin : g_spread
            logic [ACC_W-1:0] acc;
            logic [SUM_W-1:0] sum;

            always_comb begin
                sum   = SUM_W'(acc) + SUM_W'(N_LONG);
                ratio = (sum >= SUM_W'(NUM_OUT)) ? DIV_BY_3 : DIV_BY_2;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc <= '0;
                end else if (adv) begin
                    if (ratio == DIV_BY_3) acc <= ACC_W'(sum - SUM_W'(NUM_OUT));
                    else                   acc <= ACC_W'(sum);
                end
            end

            AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
                acc < ACC_W'(NUM_OUT)) else $error("accumulator out of range"); // R3

            if (N_LONG >= N_SHORT) begin : g_no_pair
                AST_NO_DOUBLE_TWO: assert property (@(posedge clk) disable iff (rst)
                    (adv && ratio == DIV_BY_2) |=> (ratio == DIV_BY_3))
                    else $error("two short cycles in a row"); // R3
            end
        end else begin : g_grouped
            localparam int unsigned IDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
            logic [IDX_W-1:0] idx;

            always_comb ratio = (idx < IDX_W'(N_LONG)) ? DIV_BY_3 : DIV_BY_2;

            always_ff @(posedge clk) begin
                if (rst) begin
                    idx <= '0;
                end else if (adv) begin
                    idx <= (idx == IDX_W'(NUM_OUT - 1)) ? '0 : idx + 1'b1;
                end
            end

            AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
                idx < IDX_W'(NUM_OUT)) else $error("slot index out of range"); // R4
        end
    endgenerate

endmodule

// File: rtl/fdiv_presc.sv
module fdiv_presc
    import fdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    output presc_s st
);
    logic [1:0] phase;

    always_comb begin
        st.phase = phase;
        st.last  = (phase == final_phase(ratio));
    end

    always_ff @(posedge clk) begin
        if (rst)          phase <= 2'd0;
        else if (st.last) phase <= 2'd0;
        else              phase <= phase + 2'd1;
    end

    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        phase <= final_phase(ratio)) else $error("prescaler overran ratio"); // R1

endmodule

// File: rtl/fdiv_shape.sv
module fdiv_shape
    import fdiv_pkg::*;
#(
    parameter bit DUTY_FIX = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    input  presc_s st,
    output logic   pulse_o,
    output logic   clk_div_o
);
    logic high_now;

    always_comb high_now = (st.phase < high_len(ratio, DUTY_FIX));

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o   <= 1'b0;
            clk_div_o <= 1'b0;
        end else begin
            pulse_o   <= st.last;
            clk_div_o <= high_now;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o) else $error("pulse wider than one clock"); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pulse_o && !clk_div_o)) else $error("output active in reset"); // R7

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 48,
    parameter int unsigned NUM_IN     = 125,
    parameter bit          MIN_JITTER = 1'b1,
    parameter bit          DUTY_FIX   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_o,
    output logic clk_div_o
);
    ratio_e ratio;
    presc_s st;

    fdiv_ctrl #(
        .NUM_OUT   (NUM_OUT),
        .NUM_IN    (NUM_IN),
        .MIN_JITTER(MIN_JITTER)
    ) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .adv  (st.last),
        .ratio(ratio)
    );

    fdiv_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .ratio(ratio),
        .st   (st)
    );

    fdiv_shape #(
        .DUTY_FIX(DUTY_FIX)
    ) u_shape (
        .clk      (clk),
        .rst      (rst),
        .ratio    (ratio),
        .st       (st),
        .pulse_o  (pulse_o),
        .clk_div_o(clk_div_o)
    );

    // Frame watch: pulses seen over each NUM_IN-clock window since reset
    localparam int unsigned MW = $clog2(NUM_IN);
    localparam int unsigned PW = $clog2(NUM_OUT + 1) + 1;
    logic [MW-1:0] win_pos;
    logic [PW-1:0] win_cnt;
    logic          win_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_pos  <= '0;
            win_cnt  <= '0;
            win_live <= 1'b0;
        end else begin
            win_live <= 1'b1;
            win_pos  <= (win_pos == MW'(NUM_IN - 1)) ? '0 : win_pos + 1'b1;
            win_cnt  <= (win_pos == '0) ? '0 : win_cnt + PW'(pulse_o);
        end
    end

    AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (rst)
        (win_pos == '0 && win_live) |-> ((win_cnt + PW'(pulse_o)) == PW'(NUM_OUT)))
        else $error("frame pulse count wrong"); // R2

endmodule

// File: tb/test_fdiv_top.sv
module test_fdiv_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 500;
    localparam int NDUT       = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic pa, ca, pb, cb, pc, cc, pd, cd;

    fdiv_top #(.NUM_OUT(48), .NUM_IN(125), .MIN_JITTER(1'b1), .DUTY_FIX(1'b1)) i_fdiv_top (
        .clk(clk), .rst(rst), .pulse_o(pa), .clk_div_o(ca));
    fdiv_top #(.NUM_OUT(48), .NUM_IN(125), .MIN_JITTER(1'b0), .DUTY_FIX(1'b0)) i_fdiv_top_grp (
        .clk(clk), .rst(rst), .pulse_o(pb), .clk_div_o(cb));
    fdiv_top #(.NUM_OUT(3), .NUM_IN(7), .MIN_JITTER(1'b1), .DUTY_FIX(1'b0)) i_fdiv_top_small (
        .clk(clk), .rst(rst), .pulse_o(pc), .clk_div_o(cc));
    fdiv_top #(.NUM_OUT(5), .NUM_IN(13), .MIN_JITTER(1'b0), .DUTY_FIX(1'b1)) i_fdiv_top_mid (
        .clk(clk), .rst(rst), .pulse_o(pd), .clk_div_o(cd));

    int cfg_out  [NDUT] = '{48, 48, 3, 5};
    int cfg_in   [NDUT] = '{125, 125, 7, 13};
    bit cfg_mj   [NDUT] = '{1'b1, 1'b0, 1'b1, 1'b0};
    bit cfg_duty [NDUT] = '{1'b1, 1'b0, 1'b0, 1'b1};

    int checks = 0;
    int errors = 0;

    // {pulse, clk} expected j clocks after the first edge following reset release
    function automatic logic [1:0] expect_at(int n_out, int n_in, bit mj, bit duty, int j);
        int s = 0;
        int acc = 0;
        int n3 = n_in - 2 * n_out;
        for (int k = 0; k <= j; k++) begin
            int r;
            int pos;
            int h;
            if (mj) begin
                if (acc + n3 >= n_out) begin r = 3; acc = acc + n3 - n_out; end
                else begin r = 2; acc = acc + n3; end
            end else begin
                r = ((k % n_out) < n3) ? 3 : 2;
            end
            if (j < s + r) begin
                pos = j - s;
                h = (duty && r == 3) ? 2 : 1;
                return {pos == r - 1, pos < h};
            end
            s += r;
        end
        return 2'b00;
    endfunction

    task automatic chk(string what, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", what, got, exp);
        end
    endtask

    function automatic logic [1:0] got_of(int d);
        case (d)
            0: return {pa, ca};
            1: return {pb, cb};
            2: return {pc, cc};
            default: return {pd, cd};
        endcase
    endfunction

    task automatic run_phase(int tag);
        int win  [NDUT];
        int lastp[NDUT];
        int prevl[NDUT];
        for (int d = 0; d < NDUT; d++) begin win[d] = 0; lastp[d] = -1; prevl[d] = 0; end
        for (int j = 0; j < RUN_LEN; j++) begin
            @(posedge clk);
            @(negedge clk);
            for (int d = 0; d < NDUT; d++) begin
                logic [1:0] g;
                logic [1:0] e;
                g = got_of(d);
                e = expect_at(cfg_out[d], cfg_in[d], cfg_mj[d], cfg_duty[d], j);
                // R1 pulse position, R3/R4 cycle order, R5/R6 high time, R7 phase after reset
                chk($sformatf("R1 R3 R4 R5 R6 R7 dut%0d run%0d clk%0d", d, tag, j), g, e);
                if (g[1]) begin
                    win[d]++;
                    if (lastp[d] >= 0) begin
                        int len;
                        len = j - lastp[d];
                        checks++;
                        if (len != 2 && len != 3) begin
                            errors++;
                            $display("FAIL R1 dut%0d cycle length actual %0d expected 2 or 3", d, len);
                        end
                        if (d == 0) begin
                            checks++;
                            if (len == 2 && prevl[d] == 2) begin
                                errors++;
                                $display("FAIL R3 adjacent short cycles actual 2,2 expected not both 2");
                            end
                        end
                        prevl[d] = len;
                    end
                    lastp[d] = j;
                end
                if ((j % cfg_in[d]) == cfg_in[d] - 1) begin
                    checks++;
                    if (win[d] != cfg_out[d]) begin
                        errors++;
                        $display("FAIL R2 dut%0d frame pulses actual %0d expected %0d", d, win[d], cfg_out[d]);
                    end
                    win[d] = 0;
                end
            end
        end
    endtask

    task automatic chk_quiet(string what);
        for (int d = 0; d < NDUT; d++) chk($sformatf("R7 %s dut%0d", what, d), got_of(d), 2'b00);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_quiet("reset state");
        rst = 1'b0;
        run_phase(0);
        // reset in the middle of a running frame
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_quiet("mid-run reset");
        repeat (2) @(negedge clk);
        chk_quiet("held reset");
        rst = 1'b0;
        run_phase(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule